// File: doc/BRIEF.md
# Power Mission State Controller

This block tracks the mission power state of a processor system and decides when to move between states. It watches an enable pin, two sleep bits, SoC-group and fault events, and a few software-written control bits. From these it picks one power sequence and a destination state, hands the sequence code to an external sequencer, and waits for the sequencer's done pulse before it commits the new state. The sequencer owns all rail timing. This block only owns the choice of sequence and the state that results.

A saturating recovery counter records warm resets and entries into the safe path. When the counter reaches a programmable threshold, the block stops restarting from the recovery state. Only a dedicated power-on reset clears the counter. The ordinary reset returns the state machine to standby and leaves the count as it was.

Top module: `pwr_mission_fsm`

## Requirements
- R1: After a power-on reset (`por_n` low), `state_o` is STANDBY (0), `seq_req` is 0, `seq_code` is 0 and `recov_cnt` is 0. State codes: STANDBY=0, ACTIVE=1, MCU_ONLY=2, RETENTION=3, LP_STANDBY=4, SAFE=5, SAFE_RECOVERY=6.
- R2: Sequence codes are SEVERE=1, ORDERLY=2, TO_STANDBY=3, WARM_ALL=4, WARM_MCU=5, TO_ACTIVE=6, TO_MCU=7, TO_RET=8. In a powered state (ACTIVE, MCU_ONLY or RETENTION), triggers are ranked from highest to lowest as follows: `severe_flt` (code 1, to SAFE), `orderly_flt` (code 2, to SAFE), an off request (code 3), a warm fault (`wdog_flt` or `esm_flt`), `soc_err`, and then the sleep and wake requests.
- R3: A request raises `seq_req` one cycle after the trigger is sampled. `seq_req` and `seq_code` then hold until the clock edge that samples `seq_done`. At that edge `state_o` takes the destination and `seq_req` falls. Triggers that arrive while a request is outstanding are ignored.
- R4: In a powered state, `enable_pin` low or `sw_standby` high requests TO_STANDBY. The destination is LP_STANDBY when `lp_sel` is 1 and STANDBY when it is 0.
- R5: In STANDBY or LP_STANDBY, `enable_pin` high with `sw_standby` low requests start-up. A `startup_dest` of 3 gives TO_ACTIVE to ACTIVE. Any other value gives TO_MCU to MCU_ONLY. With `enable_pin` low, no request is made.
- R6: In ACTIVE, `sleep_bits`=3 makes no request. `sleep_bits`=0 with `ret_hold`=1 requests TO_RET to RETENTION. Any other case requests TO_MCU. RETENTION holds while `sleep_bits`=0. Any nonzero value wakes it with TO_MCU.
- R7: MCU_ONLY requests TO_ACTIVE only when `sleep_bits`=3, `err_irq_pend`=0 and `soc_err`=0.
- R8: `soc_err` in ACTIVE requests TO_MCU to MCU_ONLY.
- R9: A warm fault requests WARM_ALL in ACTIVE and WARM_MCU in MCU_ONLY. The state does not change, and `recov_cnt` increments when `seq_done` is taken.
- R10: One cycle after SAFE is entered, the state becomes SAFE_RECOVERY and `recov_cnt` increments in that same cycle.
- R11: `recov_halt` is 1 whenever `recov_cnt` >= `recov_thr`. In SAFE_RECOVERY with `recov_halt` set, no request is ever made. Without it, `enable_pin` high requests start-up as in R5.
- R12: `recov_cnt` saturates at its maximum value. `rst_n` does not clear it; only `por_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the state machine |
| por_n | input | 1 | Synchronous active-low power-on reset; also clears the counter |
| enable_pin | input | 1 | System enable level |
| sleep_bits | input | 2 | Sleep request bits (3 = full power) |
| sw_standby | input | 1 | Software request for standby |
| ret_hold | input | 1 | Software retention permit, held by software |
| lp_sel | input | 1 | Off destination select (1 = LP_STANDBY) |
| startup_dest | input | 2 | Start-up destination field (3 = ACTIVE) |
| soc_err | input | 1 | SoC power-group error |
| err_irq_pend | input | 1 | Error interrupts not yet cleared |
| severe_flt | input | 1 | Severe fault |
| orderly_flt | input | 1 | Orderly fault |
| wdog_flt | input | 1 | Watchdog fault (warm reset) |
| esm_flt | input | 1 | Error-monitor fault (warm reset) |
| recov_thr | input | CW | Recovery threshold |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_req | output | 1 | Request outstanding |
| seq_code | output | 4 | Requested sequence code |
| state_o | output | 3 | Current mission state |
| recov_cnt | output | CW | Recovery count |
| recov_halt | output | 1 | Recovery attempts exhausted |

## Verification
The assertions assume that `recov_thr` is constant while the block sits in SAFE_RECOVERY. They also assume that `seq_done` is only meaningful while `seq_req` is high. The bench sets the threshold only right after a power-on reset, and it pulses `seq_done` only after it has seen a request. Every trigger is driven on the falling edge. The bench clears the triggers before it returns `seq_done`, so that no trigger overlaps a commit edge by accident, except in the one case that deliberately tests that triggers are ignored while a request is outstanding.

// File: rtl/pmf_pkg.sv
// Shared encodings for the power mission state controller.
// Assumes: state and sequence codes are fixed and visible at the ports.
package pmf_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY    = 3'd0,
        ST_ACTIVE     = 3'd1,
        ST_MCU_ONLY   = 3'd2,
        ST_RETENTION  = 3'd3,
        ST_LP_STANDBY = 3'd4,
        ST_SAFE       = 3'd5,
        ST_SAFE_RECOV = 3'd6
    } pm_state_e;

    typedef enum logic [3:0] {
        SQ_NONE      = 4'd0,
        SQ_SEVERE    = 4'd1,
        SQ_ORDERLY   = 4'd2,
        SQ_STANDBY   = 4'd3,
        SQ_WARM_ALL  = 4'd4,
        SQ_WARM_MCU  = 4'd5,
        SQ_TO_ACTIVE = 4'd6,
        SQ_TO_MCU    = 4'd7,
        SQ_TO_RET    = 4'd8
    } pm_seq_e;

    typedef struct packed {
        logic      valid;
        pm_seq_e   code;
        pm_state_e dest;
        logic      warm;
    } pm_req_t;
endpackage

// File: rtl/pmf_trig_arb.sv
// Trigger arbiter: picks at most one sequence request from the current
// state and the trigger levels, in fixed priority order.
// Assumes: the caller samples the result only when no request is outstanding.
module pmf_trig_arb
    import pmf_pkg::*;
(
    input  pm_state_e  cur,
    input  logic       enable_pin,
    input  logic [1:0] sleep_bits,
    input  logic       sw_standby,
    input  logic       ret_hold,
    input  logic       lp_sel,
    input  logic [1:0] startup_dest,
    input  logic       soc_err,
    input  logic       err_irq_pend,
    input  logic       severe_flt,
    input  logic       orderly_flt,
    input  logic       warm_flt,
    input  logic       halted,
    output pm_req_t    req
);
    localparam logic [1:0] FULL_PWR = 2'b11;

    logic      powered;
    logic      off_req;
    logic      wake_ok;
    pm_state_e up_dest;
    pm_seq_e   up_code;
    pm_state_e low_dest;

    // Shared decode of the off, wake and destination choices.
    always_comb begin
        powered  = (cur == ST_ACTIVE) || (cur == ST_MCU_ONLY) || (cur == ST_RETENTION);
        off_req  = !enable_pin || sw_standby;
        wake_ok  = enable_pin && !sw_standby;
        up_dest  = (startup_dest == 2'b11) ? ST_ACTIVE : ST_MCU_ONLY;
        up_code  = (startup_dest == 2'b11) ? SQ_TO_ACTIVE : SQ_TO_MCU;
        low_dest = lp_sel ? ST_LP_STANDBY : ST_STANDBY;
    end

    // Priority encode: severe, orderly, off, warm, SoC error, sleep/wake.
    always_comb begin
        req.valid = 1'b0;
        req.code  = SQ_NONE;
        req.dest  = cur;
        req.warm  = 1'b0;
        if (powered && severe_flt) begin
            req.valid = 1'b1; req.code = SQ_SEVERE;  req.dest = ST_SAFE;
        end else if (powered && orderly_flt) begin
            req.valid = 1'b1; req.code = SQ_ORDERLY; req.dest = ST_SAFE;
        end else if (powered && off_req) begin
            req.valid = 1'b1; req.code = SQ_STANDBY; req.dest = low_dest;
        end else if (cur == ST_ACTIVE && warm_flt) begin
            req.valid = 1'b1; req.code = SQ_WARM_ALL; req.dest = ST_ACTIVE; req.warm = 1'b1;
        end else if (cur == ST_MCU_ONLY && warm_flt) begin
            req.valid = 1'b1; req.code = SQ_WARM_MCU; req.dest = ST_MCU_ONLY; req.warm = 1'b1;
        end else if (cur == ST_ACTIVE && soc_err) begin
            req.valid = 1'b1; req.code = SQ_TO_MCU; req.dest = ST_MCU_ONLY;
        end else begin
            case (cur)
                ST_ACTIVE: begin
                    if (sleep_bits == 2'b00 && ret_hold) begin
                        req.valid = 1'b1; req.code = SQ_TO_RET; req.dest = ST_RETENTION;
                    end else if (sleep_bits != FULL_PWR) begin
                        req.valid = 1'b1; req.code = SQ_TO_MCU; req.dest = ST_MCU_ONLY;
                    end
                end
                ST_MCU_ONLY: begin
                    if (sleep_bits == FULL_PWR && !err_irq_pend && !soc_err) begin
                        req.valid = 1'b1; req.code = SQ_TO_ACTIVE; req.dest = ST_ACTIVE;
                    end else if (sleep_bits == 2'b00 && ret_hold) begin
                        req.valid = 1'b1; req.code = SQ_TO_RET; req.dest = ST_RETENTION;
                    end
                end
                ST_RETENTION: begin
                    if (sleep_bits != 2'b00) begin
                        req.valid = 1'b1; req.code = SQ_TO_MCU; req.dest = ST_MCU_ONLY;
                    end
                end
                ST_STANDBY, ST_LP_STANDBY: begin
                    if (wake_ok) begin
                        req.valid = 1'b1; req.code = up_code; req.dest = up_dest;
                    end
                end
                ST_SAFE_RECOV: begin
                    if (wake_ok && !halted) begin
                        req.valid = 1'b1; req.code = up_code; req.dest = up_dest;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pmf_recov_cnt.sv
// Saturating recovery counter with a threshold compare.
// Assumes: inc is a single-cycle event; only por_n clears the count.
module pmf_recov_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          inc,
    input  logic [CW-1:0] thr,
    output logic [CW-1:0] cnt,
    output logic          halted
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Count events, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!por_n)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    // Recovery is exhausted once the count reaches the threshold.
    assign halted = (cnt >= thr);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        inc |=> (cnt == $past(cnt) + 1'b1) || ($past(cnt) == CNT_MAX));
    // R12
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/pwr_mission_fsm.sv
// Power mission state controller. Holds the mission state, issues one
// sequence request at a time to an external sequencer and commits the
// destination on its done pulse. Warm resets and safe entries feed the
// recovery counter.
// Assumes: seq_done is meaningful only while seq_req is high;
// recov_thr is static while in SAFE_RECOVERY.
module pwr_mission_fsm
    import pmf_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          enable_pin,
    input  logic [1:0]    sleep_bits,
    input  logic          sw_standby,
    input  logic          ret_hold,
    input  logic          lp_sel,
    input  logic [1:0]    startup_dest,
    input  logic          soc_err,
    input  logic          err_irq_pend,
    input  logic          severe_flt,
    input  logic          orderly_flt,
    input  logic          wdog_flt,
    input  logic          esm_flt,
    input  logic [CW-1:0] recov_thr,
    input  logic          seq_done,
    output logic          seq_req,
    output logic [3:0]    seq_code,
    output logic [2:0]    state_o,
    output logic [CW-1:0] recov_cnt,
    output logic          recov_halt
);
    pm_state_e state_q;
    pm_state_e dest_q;
    pm_seq_e   code_q;
    logic      busy_q;
    logic      warm_q;
    logic      fsm_rst_n;
    logic      cnt_inc;
    pm_req_t   req;

    assign fsm_rst_n = rst_n && por_n;

    pmf_trig_arb u_arb (
        .cur          (state_q),
        .enable_pin   (enable_pin),
        .sleep_bits   (sleep_bits),
        .sw_standby   (sw_standby),
        .ret_hold     (ret_hold),
        .lp_sel       (lp_sel),
        .startup_dest (startup_dest),
        .soc_err      (soc_err),
        .err_irq_pend (err_irq_pend),
        .severe_flt   (severe_flt),
        .orderly_flt  (orderly_flt),
        .warm_flt     (wdog_flt || esm_flt),
        .halted       (recov_halt),
        .req          (req)
    );

    // Count on a committed warm reset or on the step out of SAFE.
    assign cnt_inc = fsm_rst_n &&
                     ((busy_q && seq_done && warm_q) || (!busy_q && state_q == ST_SAFE));

    pmf_recov_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .por_n  (por_n),
        .inc    (cnt_inc),
        .thr    (recov_thr),
        .cnt    (recov_cnt),
        .halted (recov_halt)
    );

    // Mission state, request latch and commit on sequencer done.
    always_ff @(posedge clk) begin
        if (!fsm_rst_n) begin
            state_q <= ST_STANDBY;
            dest_q  <= ST_STANDBY;
            code_q  <= SQ_NONE;
            busy_q  <= 1'b0;
            warm_q  <= 1'b0;
        end else if (busy_q) begin
            if (seq_done) begin
                state_q <= dest_q;
                code_q  <= SQ_NONE;
                busy_q  <= 1'b0;
                warm_q  <= 1'b0;
            end
        end else if (state_q == ST_SAFE) begin
            state_q <= ST_SAFE_RECOV;
        end else if (req.valid) begin
            busy_q <= 1'b1;
            code_q <= req.code;
            dest_q <= req.dest;
            warm_q <= req.warm;
        end
    end

    assign seq_req  = busy_q;
    assign seq_code = code_q;
    assign state_o  = state_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (seq_req && !seq_done) |=> (seq_req && $stable(seq_code)));
    // R3
    state_hold_chk: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (!(seq_req && seq_done) && state_q != ST_SAFE) |=> $stable(state_o));
    // R10
    safe_step_chk: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (state_q == ST_SAFE) |=> (state_q == ST_SAFE_RECOV));
    // R6
    ret_gate_chk: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        ($rose(seq_req) && seq_code == SQ_TO_RET) |-> $past(ret_hold));
    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (state_q == ST_SAFE_RECOV && recov_halt && !seq_req) |=> !seq_req);
endmodule

// File: tb/tb_pwr_mission_fsm.sv
module tb_pwr_mission_fsm;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b1, por_n = 1'b0;
    logic enable_pin, sw_standby, ret_hold, lp_sel, soc_err, err_irq_pend;
    logic severe_flt, orderly_flt, wdog_flt, esm_flt, seq_done;
    logic [1:0] sleep_bits, startup_dest;
    logic [CW-1:0] recov_thr = 4'd15;
    logic seq_req, recov_halt;
    logic [3:0] seq_code;
    logic [2:0] state_o;
    logic [CW-1:0] recov_cnt;

    int n_chk = 0, n_err = 0;
    logic q_en, q_ret, q_lp, q_irq;
    logic [1:0] q_sleep, q_sd;

    always #5 clk = ~clk;

    pwr_mission_fsm #(.CW(CW)) dut (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        enable_pin = q_en; sleep_bits = q_sleep; sw_standby = 1'b0; ret_hold = q_ret;
        lp_sel = q_lp; startup_dest = q_sd; soc_err = 1'b0; err_irq_pend = q_irq;
        severe_flt = 1'b0; orderly_flt = 1'b0; wdog_flt = 1'b0; esm_flt = 1'b0;
        seq_done = 1'b0;
    endtask

    task automatic defaults();
        q_en = 1'b1; q_ret = 1'b0; q_lp = 1'b0; q_irq = 1'b0; q_sleep = 2'b11; q_sd = 2'b11;
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0; quiet();
        repeat (2) @(posedge clk);
        @(negedge clk); por_n = 1'b1;
    endtask

    // Expect a request at the next edge, then complete it.
    task automatic seq(int code, int st, string tag);
        @(posedge clk); @(negedge clk);
        chk({tag, " req"}, seq_req, 1);
        chk({tag, " code"}, seq_code, code);
        quiet(); seq_done = 1'b1;
        @(posedge clk); @(negedge clk);
        seq_done = 1'b0;
        chk({tag, " state"}, state_o, st);
        chk({tag, " req low"}, seq_req, 0);
    endtask

    task automatic idle_chk(int st, string tag);
        repeat (3) @(negedge clk);
        chk({tag, " no req"}, seq_req, 0);
        chk({tag, " state"}, state_o, st);
    endtask

    task automatic bring_up();
        defaults(); do_por();
        seq(6, 1, "R5 bring-up");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        defaults(); q_en = 1'b0; quiet();
        do_por();
        // R1 reset state
        @(negedge clk);
        chk("R1 state", state_o, 0); chk("R1 req", seq_req, 0);
        chk("R1 code", seq_code, 0); chk("R1 cnt", recov_cnt, 0);
        idle_chk(0, "R5 enable low");

        // R2 priority sweep in ACTIVE
        for (int m = 1; m < 32; m++) begin
            int ec, es;
            bring_up();
            @(negedge clk);
            severe_flt = m[0]; orderly_flt = m[1]; enable_pin = !m[2];
            wdog_flt = m[3]; soc_err = m[4];
            if (m[0])      begin ec = 1; es = 5; end
            else if (m[1]) begin ec = 2; es = 5; end
            else if (m[2]) begin ec = 3; es = 0; end
            else if (m[3]) begin ec = 4; es = 1; end
            else           begin ec = 7; es = 2; end
            seq(ec, es, "R2 priority");
            if (es == 5) begin
                @(posedge clk); @(negedge clk);
                chk("R10 safe recov", state_o, 6);
                chk("R10 cnt", recov_cnt, 1);
            end
            if (ec == 4) chk("R9 warm cnt", recov_cnt, 1);
        end

        // R3 triggers ignored while busy
        bring_up();
        q_sleep = 2'b01; @(negedge clk); quiet();
        @(posedge clk); @(negedge clk);
        chk("R3 req", seq_req, 1);
        severe_flt = 1'b1; enable_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 code held", seq_code, 7);
        chk("R3 state held", state_o, 1);
        quiet(); seq_done = 1'b1;
        @(posedge clk); @(negedge clk); seq_done = 1'b0;
        chk("R3 dest kept", state_o, 2);

        // R4/R5 off and start-up sweep
        for (int sd = 0; sd < 4; sd++)
            for (int lp = 0; lp < 2; lp++)
                for (int how = 0; how < 2; how++) begin
                    bring_up();
                    q_sd = 2'(sd); q_lp = 1'(lp);
                    @(negedge clk); quiet();
                    if (how == 0) begin
                        q_en = 1'b0; enable_pin = 1'b0;
                        seq(3, lp ? 4 : 0, "R4 enable off");
                        idle_chk(lp ? 4 : 0, "R5 hold low");
                        q_en = 1'b1; @(negedge clk); quiet();
                    end else begin
                        sw_standby = 1'b1;
                        seq(3, lp ? 4 : 0, "R4 sw standby");
                    end
                    seq(sd == 3 ? 6 : 7, sd == 3 ? 1 : 2, "R5 startup");
                end

        // R6 sleep / retention sweep
        for (int sl = 0; sl < 4; sl++)
            for (int rh = 0; rh < 2; rh++) begin
                bring_up();
                q_sleep = 2'(sl); q_ret = 1'(rh);
                @(negedge clk); quiet();
                if (sl == 3) idle_chk(1, "R6 full power");
                else if (sl == 0 && rh == 1) begin
                    seq(8, 3, "R6 retention");
                    idle_chk(3, "R6 retention hold");
                    q_sleep = 2'b01; @(negedge clk); quiet();
                    seq(7, 2, "R6 retention wake");
                    idle_chk(2, "R6 mcu hold");
                end else seq(7, 2, "R6 sleep");
            end

        // R7/R8 return gating
        bring_up();
        q_irq = 1'b1; @(negedge clk); quiet(); soc_err = 1'b1;
        seq(7, 2, "R8 soc err");
        idle_chk(2, "R7 irq pending");
        q_irq = 1'b0; @(negedge clk); quiet(); soc_err = 1'b1;
        idle_chk(2, "R7 soc err held");
        @(negedge clk); soc_err = 1'b0;
        seq(6, 1, "R7 return");

        // R9 warm reset in MCU_ONLY
        bring_up();
        q_sleep = 2'b01; @(negedge clk); quiet();
        seq(7, 2, "R6 to mcu");
        esm_flt = 1'b1;
        seq(5, 2, "R9 warm mcu");
        chk("R9 cnt", recov_cnt, 1);

        // R11 threshold sweep, R12 rst_n keeps count
        for (int t = 1; t < 5; t++) begin
            logic stop;
            defaults(); do_por(); recov_thr = 4'(t);
            seq(6, 1, "R5 bring-up");
            stop = 1'b0;
            for (int k = 1; k < 6 && !stop; k++) begin
                severe_flt = 1'b1;
                seq(1, 5, "R2 severe");
                @(posedge clk); @(negedge clk);
                chk("R10 recov state", state_o, 6);
                chk("R10 recov cnt", recov_cnt, k);
                chk("R11 halt flag", recov_halt, k >= t ? 1 : 0);
                if (k >= t) begin
                    idle_chk(6, "R11 halted");
                    stop = 1'b1;
                end else seq(6, 1, "R11 restart");
            end
            @(negedge clk); rst_n = 1'b0;
            repeat (2) @(negedge clk); rst_n = 1'b1;
            chk("R12 rst keeps cnt", recov_cnt, t);
            chk("R12 rst state", state_o, 0);
            do_por();
            chk("R12 por clears", recov_cnt, 0);
        end

        // R12 saturation
        recov_thr = 4'd15;
        bring_up();
        for (int k = 1; k < 18; k++) begin
            if (k % 2 == 1) wdog_flt = 1'b1; else esm_flt = 1'b1;
            seq(4, 1, "R9 warm all");
            chk("R12 saturate", recov_cnt, k > 15 ? 15 : k);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule